// File: doc/BRIEF.md
# Clock source switch sequencer

This block owns the choice of system clock source. It leaves reset with the internal RC oscillator selected. Software asks for a new source (RC, crystal or PLL) and a flash wait-state value on a single-cycle request strobe. The block then runs the change in a fixed order. For a PLL target, it waits for the input reference to report stable. It then enables the PLL and waits for lock, with a programmable limit on each wait. Depending on the direction, it updates the wait states either before or after the source switch. It changes the mux select break-before-make, so two clocks are never selected together.

The direction comes from the wait-state value. If the requested value is larger than the value now in force, the move is treated as a speed-up: wait states are raised first, then the mux switches. Otherwise the mux switches first and the wait states are lowered afterwards. If reference or lock does not arrive in time, the sequence is abandoned. The old source stays selected, the PLL enable drops and an error flag is raised.

States: `ST_IDLE` (waiting for a request), `ST_REF` (waiting for reference stable), `ST_LOCK` (PLL enabled, waiting for lock), `ST_WS_UP` (wait states raised), `ST_RELEASE` (all selects low), `ST_ENGAGE` (new select high), `ST_WS_DN` (wait states lowered), `ST_DONE` (completion pulse). Transitions:
- `ST_IDLE` moves to `ST_REF` for a PLL target, to `ST_WS_UP` for a speed-up, and to `ST_RELEASE` otherwise.
- `ST_REF` moves to `ST_LOCK` on reference stable, or back to `ST_IDLE` on timeout.
- `ST_LOCK` moves to `ST_WS_UP` or `ST_RELEASE` on lock, or back to `ST_IDLE` on timeout.
- `ST_WS_UP` moves to `ST_RELEASE`.
- `ST_RELEASE` moves to `ST_ENGAGE` after `SYNC_STAGES` cycles.
- `ST_ENGAGE` moves to `ST_DONE` (speed-up) or `ST_WS_DN` (otherwise) after `SYNC_STAGES` cycles.
- `ST_WS_DN` moves to `ST_DONE`, and `ST_DONE` moves to `ST_IDLE`.

Top module: `clksrc_seq`

## Requirements
- R1: After reset, `clk_sel` is 3'b001 (bit 0 RC, bit 1 crystal, bit 2 PLL), `cur_src` is 0, `flash_ws` is 0, and `pll_en`, `busy`, `done` and `err` are low.
- R2: `clk_sel` never has more than one bit set. Between any two different sources, it is all-zero for exactly `SYNC_STAGES` cycles (default 2).
- R3: `pll_en` rises only after `ref_stable` has been seen high.
- R4: `clk_sel[2]` (PLL) is high only while `pll_lock` is high.
- R5: When the requested wait state is above the current one, `flash_ws` takes the new value before the new source is selected.
- R6: When the requested wait state is not above the current one, the new source is selected first and `flash_ws` changes afterwards.
- R7: If reference stable or lock is not seen within `lock_limit`+1 cycles of waiting, the sequence ends without `done`. `err` goes high, `pll_en` drops, and `cur_src` and `flash_ws` keep their old values.
- R8: `busy` is high from the cycle after an accepted request until the sequence ends. A request is ignored while busy, when `req_src` equals `cur_src`, or when `req_src` is 3 (source codes: 0 RC, 1 crystal, 2 PLL).
- R9: A completed sequence gives exactly one `done` cycle, with `busy` high and `cur_src` already showing the new source. The next accepted request clears `err`.
- R10: Once a move onto a non-PLL source completes, `pll_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_src | input | 2 | Requested source code (0 RC, 1 crystal, 2 PLL) |
| req_ws | input | WS_W | Requested flash wait states |
| lock_limit | input | TO_W | Wait limit for reference and lock, in cycles |
| ref_stable | input | 1 | Input reference reported stable |
| pll_lock | input | 1 | PLL lock indication |
| pll_en | output | 1 | PLL enable |
| flash_ws | output | WS_W | Flash wait states in force |
| clk_sel | output | 3 | One-hot mux select (bit 0 RC, bit 1 crystal, bit 2 PLL) |
| cur_src | output | 2 | Source code now selected |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last sequence timed out |

## Verification
The bench first delays the reference for several cycles, so that a design which enables the PLL early would show `pll_en` rising while `ref_stable` is low. It then drives a PLL that never locks and a reference that never settles. A design without the timeout would hang busy, and one that switches anyway would leave the PLL selected without lock. It sends requests while busy, for the current source and with the unused code. A design that accepted any of these would start a second sequence or end on the wrong source. It records the cycle of each wait-state change against the cycle the new select appears, in both directions, so a reversed order is caught. It also counts the all-zero select gap, so an overlap or a missing gap is caught.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    typedef enum logic [1:0] {
        SRC_RC   = 2'd0,
        SRC_XTAL = 2'd1,
        SRC_PLL  = 2'd2
    } src_e;

    localparam int NUM_SRC = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REF,
        ST_LOCK,
        ST_WS_UP,
        ST_RELEASE,
        ST_ENGAGE,
        ST_WS_DN,
        ST_DONE
    } state_e;

endpackage

// File: rtl/clkseq_cnt.sv
module clkseq_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + W'(1);
        end
    end
endmodule

// File: rtl/clkseq_onehot.sv
module clkseq_onehot #(
    parameter int N = 3,
    parameter int W = 2
) (
    input  logic         en,
    input  logic [W-1:0] idx,
    output logic [N-1:0] oh
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign oh[i] = en && (idx == W'(i));
    end
endmodule

// File: rtl/clksrc_seq.sv
module clksrc_seq
    import clkseq_pkg::*;
#(
    parameter int WS_W        = 4,
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_src,
    input  logic [WS_W-1:0] req_ws,
    input  logic [TO_W-1:0] lock_limit,
    input  logic            ref_stable,
    input  logic            pll_lock,
    output logic            pll_en,
    output logic [WS_W-1:0] flash_ws,
    output logic [2:0]      clk_sel,
    output logic [1:0]      cur_src,
    output logic            busy,
    output logic            done,
    output logic            err
);
    localparam logic [TO_W-1:0] SYNC_LAST = TO_W'(SYNC_STAGES - 1);

    state_e          state_q, state_d;
    src_e            cur_q, tgt_q;
    logic [WS_W-1:0] ws_q, tgt_ws_q;
    logic            up_q, err_q, pll_en_q;
    logic [TO_W-1:0] cnt_q;
    logic            cnt_clr, cnt_inc, fail, accept, req_up, sync_end;
    logic            sel_en;
    src_e            sel_idx;

    assign req_up   = req_ws > ws_q;
    assign accept   = (state_q == ST_IDLE) && req_valid &&
                      (req_src != 2'd3) && (req_src != cur_q);
    assign sync_end = (cnt_q == SYNC_LAST);

    clkseq_cnt #(.W(TO_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .q    (cnt_q)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        fail    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (accept) begin
                    if (req_src == SRC_PLL) state_d = ST_REF;
                    else if (req_up)        state_d = ST_WS_UP;
                    else                    state_d = ST_RELEASE;
                end
            end
            ST_REF: begin
                if (ref_stable) begin
                    state_d = ST_LOCK;
                    cnt_clr = 1'b1;
                end else if (cnt_q == lock_limit) begin
                    state_d = ST_IDLE;
                    fail    = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_LOCK: begin
                if (pll_lock) begin
                    state_d = up_q ? ST_WS_UP : ST_RELEASE;
                    cnt_clr = 1'b1;
                end else if (cnt_q == lock_limit) begin
                    state_d = ST_IDLE;
                    fail    = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_WS_UP: begin
                state_d = ST_RELEASE;
                cnt_clr = 1'b1;
            end
            ST_RELEASE: begin
                if (sync_end) begin
                    state_d = ST_ENGAGE;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_ENGAGE: begin
                if (sync_end) begin
                    state_d = up_q ? ST_DONE : ST_WS_DN;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_WS_DN: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State and sequence registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_q    <= SRC_RC;
            tgt_q    <= SRC_RC;
            ws_q     <= '0;
            tgt_ws_q <= '0;
            up_q     <= 1'b0;
            err_q    <= 1'b0;
            pll_en_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                tgt_q    <= src_e'(req_src);
                tgt_ws_q <= req_ws;
                up_q     <= req_up;
                err_q    <= 1'b0;
            end
            if (fail) begin
                err_q    <= 1'b1;
                pll_en_q <= 1'b0;
            end
            if (state_q == ST_REF && state_d == ST_LOCK) begin
                pll_en_q <= 1'b1;
            end
            if (state_q == ST_WS_UP || state_q == ST_WS_DN) begin
                ws_q <= tgt_ws_q;
            end
            if (state_q == ST_ENGAGE && state_d != ST_ENGAGE) begin
                cur_q <= tgt_q;
            end
            if (state_q == ST_DONE) begin
                pll_en_q <= (tgt_q == SRC_PLL);
            end
        end
    end

    // Outputs
    always_comb begin
        sel_en  = 1'b1;
        sel_idx = cur_q;
        busy    = (state_q != ST_IDLE);
        done    = 1'b0;
        unique case (state_q)
            ST_RELEASE: sel_en  = 1'b0;
            ST_ENGAGE:  sel_idx = tgt_q;
            ST_DONE:    done    = 1'b1;
            default:    ;
        endcase
    end

    clkseq_onehot #(.N(NUM_SRC), .W(2)) u_sel (
        .en (sel_en),
        .idx(sel_idx),
        .oh (clk_sel)
    );

    assign pll_en   = pll_en_q;
    assign flash_ws = ws_q;
    assign cur_src  = cur_q;
    assign err      = err_q;

endmodule

// File: rtl/clkseq_sva.sv
module clkseq_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] clk_sel,
    input logic       pll_en,
    input logic       pll_lock,
    input logic       ref_stable,
    input logic       busy,
    input logic       done,
    input logic       err
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_on_rc: assert (clk_sel == 3'b001 && !pll_en && !busy && !err)
                else $error("R1 reset state wrong");
        end
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clk_sel));

    a_r2_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != 3'b000 && $past(clk_sel) != 3'b000) |-> clk_sel == $past(clk_sel));

    a_r3_ref_before_pll: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> $past(ref_stable));

    a_r4_lock_before_pll: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel[2] |-> pll_lock);

    a_r7_err_ends_seq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy && !pll_en);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy && !err);

    a_r10_pll_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !clk_sel[2]) |-> !pll_en);

endmodule

bind clksrc_seq clkseq_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_sel   (clk_sel),
    .pll_en    (pll_en),
    .pll_lock  (pll_lock),
    .ref_stable(ref_stable),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/clksrc_seq_bench.sv
module clksrc_seq_bench;
    localparam int WS_W = 4;
    localparam int TO_W = 16;
    localparam int SYNC = 2;
    localparam int LIMIT = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_src = 2'd0;
    logic [WS_W-1:0] req_ws = '0;
    logic [TO_W-1:0] lock_limit = TO_W'(LIMIT);
    logic            ref_stable = 1'b1;
    logic            pll_lock = 1'b0;
    logic            pll_en, busy, done, err;
    logic [WS_W-1:0] flash_ws;
    logic [2:0]      clk_sel;
    logic [1:0]      cur_src;

    always #10 clk = ~clk;

    clksrc_seq #(.WS_W(WS_W), .TO_W(TO_W), .SYNC_STAGES(SYNC)) u_clksrc_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_ws(req_ws), .lock_limit(lock_limit), .ref_stable(ref_stable),
        .pll_lock(pll_lock), .pll_en(pll_en), .flash_ws(flash_ws),
        .clk_sel(clk_sel), .cur_src(cur_src), .busy(busy), .done(done), .err(err)
    );

    typedef struct {
        int src;
        int ws;
        bit err;
        bit up;
        bit moves;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    int   m_src = 0;
    int   m_ws = 0;
    int   ref_hold = 0;
    int   lock_delay = 3;
    int   lk_cnt = 0;

    int   cyc = 0;
    int   ws_cyc = -1;
    int   sel_cyc = -1;
    int   zrun = 0;
    int   done_cnt = 0;
    bit   saw_busy = 0;
    logic busy_p = 0;
    logic pll_en_p = 0;
    logic [2:0] sel_p = 3'b001;
    logic [WS_W-1:0] ws_p = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: cycle-level checks, scoreboard pop, PLL and reference models
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (busy && !busy_p) begin
                ws_cyc = -1; sel_cyc = -1; done_cnt = 0;
            end
            if (busy) saw_busy = 1;
            if (done) done_cnt++;
            chk($countones(clk_sel) <= 1, "R2 select one-hot", int'(clk_sel), 1);
            if (clk_sel != 0 && sel_p != 0)
                chk(clk_sel == sel_p, "R2 no direct source change", int'(clk_sel), int'(sel_p));
            if (clk_sel == 0) zrun++;
            else begin
                if (sel_p == 0) begin
                    chk(zrun == SYNC, "R2 release gap length", zrun, SYNC);
                    sel_cyc = cyc;
                end
                zrun = 0;
            end
            if (pll_en && !pll_en_p)
                chk(ref_stable, "R3 PLL enabled after reference stable", ref_stable, 1);
            if (clk_sel[2])
                chk(pll_lock, "R4 PLL selected only with lock", pll_lock, 1);
            if (flash_ws != ws_p) ws_cyc = cyc;
            if (!busy && busy_p) begin
                if (sb.size() == 0) begin
                    chk(0, "R8 unexpected sequence", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(int'(cur_src) == e.src, "R9/R7 final source", cur_src, e.src);
                    chk(int'(flash_ws) == e.ws, "R7 final wait states", flash_ws, e.ws);
                    chk(err == e.err, "R7/R9 error flag", err, e.err);
                    chk(done_cnt == (e.err ? 0 : 1), "R9 done pulse count", done_cnt, e.err ? 0 : 1);
                    chk(pll_en == (e.src == 2), "R10 PLL enable after sequence", pll_en, e.src == 2);
                    if (!e.err && e.moves) begin
                        if (e.up) chk(ws_cyc < sel_cyc, "R5 wait states before switch", ws_cyc, sel_cyc);
                        else      chk(ws_cyc > sel_cyc, "R6 switch before wait states", ws_cyc, sel_cyc);
                    end
                end
            end
        end
        busy_p = busy; pll_en_p = pll_en; sel_p = clk_sel; ws_p = flash_ws;
        // stimulus models
        if (ref_hold > 0) begin ref_stable = 0; ref_hold--; end
        else ref_stable = 1;
        if (!pll_en) begin lk_cnt = 0; pll_lock = 0; end
        else if (lk_cnt >= lock_delay) pll_lock = 1;
        else lk_cnt++;
    end

    task automatic pulse_req(input int src, input int ws);
        @(negedge clk);
        req_valid = 1; req_src = 2'(src); req_ws = WS_W'(ws);
        @(negedge clk);
        req_valid = 0;
    endtask

    // Driver: pushes the expected outcome, then runs the request
    task automatic do_req(input int src, input int ws, input int rhold,
                          input int ldel, input bit fails, input int intr);
        exp_t e;
        e.err = fails; e.up = ws > m_ws; e.moves = ws != m_ws;
        e.src = fails ? m_src : src;
        e.ws  = fails ? m_ws : ws;
        sb.push_back(e);
        lock_delay = ldel;
        ref_hold = rhold;
        pulse_req(src, ws);
        if (intr >= 0) begin
            repeat (2) @(negedge clk);
            pulse_req(intr, 7);
        end
        while (busy) @(negedge clk);
        if (!fails) begin m_src = src; m_ws = ws; end
        ref_hold = 0;
        @(negedge clk);
    endtask

    task automatic expect_ignored(input int src, input int ws, input string tag);
        saw_busy = 0;
        pulse_req(src, ws);
        repeat (6) @(negedge clk);
        chk(!saw_busy, tag, saw_busy, 0);
        chk(int'(cur_src) == m_src && int'(flash_ws) == m_ws, tag, cur_src, m_src);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(clk_sel == 3'b001, "R1 reset select", clk_sel, 1);
        chk(cur_src == 0 && flash_ws == 0, "R1 reset source and wait states", flash_ws, 0);
        chk(!pll_en && !busy && !done && !err, "R1 reset flags", {pll_en, busy, done, err}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        do_req(1, 1, 0, 3, 0, -1);            // R5 speed-up onto crystal
        do_req(2, 3, 4, 5, 0, 0);             // R3 R4 R5 PLL, late reference, R8 request while busy
        repeat (3) @(negedge clk);
        chk(!busy && cur_src == 2, "R8 request during busy ignored", cur_src, 2);
        expect_ignored(2, 5, "R8 request for current source ignored");
        do_req(1, 1, 0, 3, 0, -1);            // R6 R10 off the PLL
        do_req(0, 0, 0, 3, 0, -1);            // R6 back to RC
        do_req(2, 2, 0, 100000, 1, -1);       // R7 lock timeout
        do_req(2, 2, 0, 3, 0, -1);            // R9 error cleared on success
        do_req(0, 0, 0, 3, 0, -1);            // R6 R10
        expect_ignored(3, 4, "R8 unused source code ignored");
        do_req(2, 4, 100000, 3, 1, -1);       // R7 reference timeout
        chk(!pll_en, "R3 R7 PLL never enabled without reference", pll_en, 0);
        do_req(1, 0, 0, 3, 0, -1);            // R6 equal wait states, R9 clears error
        chk(sb.size() == 0, "R9 all sequences completed", sb.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule